// File: doc/BRIEF.md
# Host Reset Request Register

This block is a small control and status register through which a host asks an embedded processor to reset. The host writes it through a bus-slave port. It can ask for a soft reset of the firmware state, or for a coordinated reset of several functions. Either request on its own is latched and raises an interrupt to the processor. If one host write sets both request bits together, the block raises no interrupt. Instead it starts an internal bus reset pulse at once and records the cause in a sticky flag that software reads afterwards.

The processor has its own port to the register. A read on that port returns the request bits and clears them. A separate strobe clears the cause flag. Neither port is a stream. Each is a single-cycle register access that the block accepts in every cycle, so there is no back-pressure. Read data is combinational from the current register contents.

Top module: `hrr_top`

## Requirements
- R1: After `rst_n` is low at a clock edge, both request bits, `irq`, `bus_rst` and `cause_flag` are 0.
- R2: A host write with bit 0 set and bit 1 clear sets the soft-reset request (bit 0) in the next cycle and raises `irq`, with no `bus_rst`.
- R3: With `mf_mode` = 1, a host write with bit 1 set and bit 0 clear sets the coordinated request (bit 1) in the next cycle and raises `irq`.
- R4: With `mf_mode` = 0, bit 1 of a host write is ignored. A write of 3 then acts as a write of 1 and starts no bus reset.
- R5: With `mf_mode` = 1, a single host write with bits 1 and 0 both set raises `bus_rst` from the next cycle for exactly `RST_CYCLES` (default 16) cycles. Throughout the pulse `irq` stays low and both request bits read 0. Host writes made during the pulse have no effect.
- R6: The combined write sets `cause_flag` in the next cycle. The flag stays set through the pulse and afterwards. Only `cpu_cause_clr` or `rst_n` clears it.
- R7: Bits 31:2 read as 0 on both read ports, whatever the host writes.
- R8: A host write of 0 to a request bit leaves that bit unchanged.
- R9: `cpu_rd_clr` returns the current request bits on `cpu_rd_data` in the same cycle and clears them in the next cycle. `irq` is the OR of the two request bits.
- R10: When a host set and `cpu_rd_clr` fall in the same cycle, the bit the host sets is 1 afterwards. The other bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| mf_mode | input | 1 | 1 enables the coordinated-reset request bit |
| host_wr_en | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data |
| host_rd_data | output | 32 | Register contents seen from the host port |
| cpu_rd_clr | input | 1 | Processor read strobe, clears the request bits |
| cpu_rd_data | output | 32 | Register contents seen from the processor port |
| cpu_cause_clr | input | 1 | Processor clear of the reset-cause flag |
| irq | output | 1 | Interrupt to the processor |
| bus_rst | output | 1 | Internal bus reset pulse |
| cause_flag | output | 1 | Sticky flag recording a combined-write bus reset |

## Verification
The assertions take `mf_mode` to be steady across the edge at which a host write is captured. They also take every strobe to be a clean 0 or 1 sampled at the clock edge. The bench changes every input, `mf_mode` included, only at the falling edge. It draws write data so that the combined pattern, single bits, zero writes and reserved-bit noise all occur. Read-clear and cause-clear strobes are drawn so that they often land in the same cycle as host writes and inside bus reset pulses.

// File: rtl/hrr_pkg.sv
package hrr_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned SR_POS = 0;
  localparam int unsigned CR_POS = 1;
  localparam int unsigned REQ_W  = 2;

  typedef struct packed {
    logic set_sr;
    logic set_cr;
    logic combo;
  } hrr_wr_t;

  function automatic hrr_wr_t decode_wr(input logic wen, input logic [REG_W-1:0] wd,
                                        input logic mf);
    hrr_wr_t d;
    d.combo  = wen & wd[SR_POS] & wd[CR_POS] & mf;
    d.set_sr = wen & wd[SR_POS] & ~d.combo;
    d.set_cr = wen & wd[CR_POS] & mf & ~d.combo;
    return d;
  endfunction
endpackage

// File: rtl/hrr_req_bits.sv
module hrr_req_bits
  import hrr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_sr,
  input  logic             set_cr,
  input  logic             rd_clr,
  input  logic             force_clr,
  output logic [REQ_W-1:0] req
);
  logic [REQ_W-1:0] set_vec;
  logic [REQ_W-1:0] req_nxt;

  always_comb begin
    set_vec         = '0;
    set_vec[SR_POS] = set_sr;
    set_vec[CR_POS] = set_cr;
    if (force_clr) req_nxt = '0;
    else           req_nxt = (rd_clr ? '0 : req) | set_vec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) req <= '0;
    else        req <= req_nxt;
  end

  // R10: a host set beats a same-cycle read-clear
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (set_sr && !force_clr) |=> req[SR_POS]);
  // R8: without set or clear the bits hold
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_sr && !set_cr && !rd_clr && !force_clr) |=> $stable(req));
endmodule

// File: rtl/hrr_pulse.sv
module hrr_pulse #(
  parameter int unsigned RST_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic busy
);
  localparam int unsigned CNT_W = $clog2(RST_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(RST_CYCLES);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (fire && !busy) cnt <= LOAD;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  // R5: pulse only starts from a fire request
  p_start_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(fire));
  // R5: fire while idle always starts the pulse
  p_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !busy) |=> busy);
endmodule

// File: rtl/hrr_cause.sv
module hrr_cause (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  // R6: flag is sticky until cleared
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);
endmodule

// File: rtl/hrr_top.sv
module hrr_top
  import hrr_pkg::*;
#(
  parameter int unsigned RST_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mf_mode,
  input  logic             host_wr_en,
  input  logic [REG_W-1:0] host_wdata,
  output logic [REG_W-1:0] host_rd_data,
  input  logic             cpu_rd_clr,
  output logic [REG_W-1:0] cpu_rd_data,
  input  logic             cpu_cause_clr,
  output logic             irq,
  output logic             bus_rst,
  output logic             cause_flag
);
  hrr_wr_t          dec;
  logic             fire;
  logic [REQ_W-1:0] req;
  logic [REG_W-1:0] reg_view;

  assign dec  = decode_wr(host_wr_en, host_wdata, mf_mode);
  assign fire = dec.combo & ~bus_rst;

  hrr_req_bits u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_sr    (dec.set_sr & ~bus_rst),
    .set_cr    (dec.set_cr & ~bus_rst),
    .rd_clr    (cpu_rd_clr),
    .force_clr (dec.combo | bus_rst),
    .req       (req)
  );

  hrr_pulse #(.RST_CYCLES(RST_CYCLES)) u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (fire),
    .busy  (bus_rst)
  );

  hrr_cause u_cause (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (fire),
    .clr   (cpu_cause_clr),
    .flag  (cause_flag)
  );

  always_comb begin
    reg_view             = '0;
    reg_view[REQ_W-1:0]  = req;
  end

  assign host_rd_data = reg_view;
  assign cpu_rd_data  = reg_view;
  assign irq          = |req;

  // R5: combined write fires a bus reset, records the cause, no interrupt
  p_combo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_en && host_wdata[1:0] == 2'b11 && mf_mode && !bus_rst)
      |=> (bus_rst && !irq && cause_flag));
  // R5: quiet request bits during the pulse
  p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |-> (!irq && host_rd_data[1:0] == 2'b00));
  // R2: soft request alone raises the interrupt without a bus reset
  p_sr_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_en && host_wdata[1:0] == 2'b01 && !bus_rst)
      |=> (irq && host_rd_data[0] && !bus_rst));
  // R4: coordinated bit cannot be set with the mode input low
  p_cr_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mf_mode && host_rd_data[1] == 1'b0) |=> !host_rd_data[1]);
  // R7: reserved bits stay zero
  p_reserved_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_data[REG_W-1:REQ_W] == '0) && (cpu_rd_data[REG_W-1:REQ_W] == '0));
endmodule

// File: tb/hrr_top_tb_top.sv
module hrr_top_tb_top;
  localparam int unsigned RST_CYCLES = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mf_mode = 1'b0;
  logic        host_wr_en = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rd_data;
  logic        cpu_rd_clr = 1'b0;
  logic [31:0] cpu_rd_data;
  logic        cpu_cause_clr = 1'b0;
  logic        irq;
  logic        bus_rst;
  logic        cause_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic m_sr, m_cr, m_cause;
  int   m_cnt;

  always #4 clk = ~clk;

  hrr_top #(.RST_CYCLES(RST_CYCLES)) dut_i (
    .clk(clk), .rst_n(rst_n), .mf_mode(mf_mode),
    .host_wr_en(host_wr_en), .host_wdata(host_wdata), .host_rd_data(host_rd_data),
    .cpu_rd_clr(cpu_rd_clr), .cpu_rd_data(cpu_rd_data), .cpu_cause_clr(cpu_cause_clr),
    .irq(irq), .bus_rst(bus_rst), .cause_flag(cause_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_view();
    return {30'b0, m_cr, m_sr};
  endfunction

  task automatic model_step(input logic wen, input logic [31:0] wd, input logic rd,
                            input logic cc, input logic mf);
    bit busy  = (m_cnt != 0);
    bit combo = wen && wd[0] && wd[1] && mf;
    bit fire  = combo && !busy;
    if (combo || busy) begin
      m_sr = 1'b0; m_cr = 1'b0;
    end else begin
      m_sr = (rd ? 1'b0 : m_sr) | (wen && wd[0]);
      m_cr = (rd ? 1'b0 : m_cr) | (wen && wd[1] && mf);
    end
    if (fire) m_cause = 1'b1;
    else if (cc) m_cause = 1'b0;
    if (fire) m_cnt = RST_CYCLES;
    else if (busy) m_cnt = m_cnt - 1;
  endtask

  task automatic step(input logic wen, input logic [31:0] wd, input logic rd, input logic cc);
    host_wr_en = wen; host_wdata = wd; cpu_rd_clr = rd; cpu_cause_clr = cc;
    @(posedge clk);
    model_step(wen, wd, rd, cc, mf_mode);
    @(negedge clk);
    host_wr_en = 1'b0; host_wdata = '0; cpu_rd_clr = 1'b0; cpu_cause_clr = 1'b0;
  endtask

  task automatic idle();
    step(1'b0, 32'h0, 1'b0, 1'b0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_sr = 0; m_cr = 0; m_cause = 0; m_cnt = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual %h expected %h", 32'h0, 32'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    @(negedge clk);
    do_reset();
    // R1: reset state
    chk("R1 rd", host_rd_data, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 bus_rst", {31'b0, bus_rst}, 32'h0);
    chk("R1 cause", {31'b0, cause_flag}, 32'h0);

    mf_mode = 1'b1;
    step(1'b1, 32'h1, 1'b0, 1'b0);
    chk("R2 rd", host_rd_data, 32'h1);
    chk("R2 irq", {31'b0, irq}, 32'h1);
    chk("R2 no bus_rst", {31'b0, bus_rst}, 32'h0);

    step(1'b1, 32'h0, 1'b0, 1'b0);
    chk("R8 write zero", host_rd_data, 32'h1);

    step(1'b1, 32'h2, 1'b0, 1'b0);
    chk("R3 rd", host_rd_data, 32'h3);
    chk("R3 irq", {31'b0, irq}, 32'h1);

    step(1'b1, 32'hFFFF_FFFC, 1'b0, 1'b0);
    chk("R7 host reserved", host_rd_data, 32'h3);
    chk("R7 cpu reserved", cpu_rd_data, 32'h3);

    cpu_rd_clr = 1'b1;
    #1;
    chk("R9 read data", cpu_rd_data, 32'h3);
    step(1'b0, 32'h0, 1'b1, 1'b0);
    chk("R9 cleared", host_rd_data, 32'h0);
    chk("R9 irq low", {31'b0, irq}, 32'h0);

    mf_mode = 1'b0;
    step(1'b1, 32'h2, 1'b0, 1'b0);
    chk("R4 cr ignored", host_rd_data, 32'h0);
    chk("R4 irq", {31'b0, irq}, 32'h0);
    step(1'b1, 32'h3, 1'b0, 1'b0);
    chk("R4 combo as sr", host_rd_data, 32'h1);
    chk("R4 no bus_rst", {31'b0, bus_rst}, 32'h0);

    mf_mode = 1'b1;
    step(1'b1, 32'h2, 1'b1, 1'b0);
    chk("R10 set wins", host_rd_data, 32'h2);

    step(1'b1, 32'h3, 1'b0, 1'b0);
    chk("R5 bus_rst", {31'b0, bus_rst}, 32'h1);
    chk("R5 irq low", {31'b0, irq}, 32'h0);
    chk("R5 bits zero", host_rd_data, 32'h0);
    chk("R6 cause set", {31'b0, cause_flag}, 32'h1);
    begin
      int len = 1;
      step(1'b1, 32'h1, 1'b0, 1'b0);
      chk("R5 write in pulse", host_rd_data, 32'h0);
      if (bus_rst) len++;
      for (int i = 0; i < 40; i++) begin
        if (!bus_rst) break;
        idle();
        if (bus_rst) len++;
      end
      chk("R5 pulse length", len, RST_CYCLES);
    end
    chk("R6 cause survives", {31'b0, cause_flag}, 32'h1);
    step(1'b0, 32'h0, 1'b0, 1'b1);
    chk("R6 cause cleared", {31'b0, cause_flag}, 32'h0);

    step(1'b1, 32'h3, 1'b0, 1'b0);
    for (int i = 0; i < 20; i++) idle();
    do_reset();
    chk("R6 cause por", {31'b0, cause_flag}, 32'h0);

    for (int i = 0; i < 4000; i++) begin
      logic wen, rd, cc;
      logic [31:0] wd;
      wen = ($urandom_range(0, 2) == 0);
      wd  = {$urandom(), 2'b00} | 32'($urandom_range(0, 3));
      if ($urandom_range(0, 3) == 0) wd[31:2] = '0;
      rd  = ($urandom_range(0, 5) == 0);
      cc  = ($urandom_range(0, 15) == 0);
      if ($urandom_range(0, 31) == 0) mf_mode = ~mf_mode;
      step(wen, wd, rd, cc);
      chk("R9 random view", host_rd_data, exp_view());
      chk("R7 random cpu view", cpu_rd_data, exp_view());
      chk("R2 random irq", {31'b0, irq}, {31'b0, m_sr | m_cr});
      chk("R5 random bus_rst", {31'b0, bus_rst}, {31'b0, m_cnt != 0});
      chk("R6 random cause", {31'b0, cause_flag}, {31'b0, m_cause});
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule